// File: doc/BRIEF.md
# Post-Reset Identity Loader

This block fills the four identity registers of a bus-attached device (vendor, device, subsystem vendor and subsystem identifiers) without help from host software. When the active-low reset is released, it starts on its own, reads eight bytes from a byte-wide non-volatile memory port, and copies them into the registers. The bytes may live in a private reserved window of a shared boot memory, set by a base-address parameter. The load runs again after every reset, because nothing loaded before a reset or power cycle is assumed to survive.

The bus-side target logic presents configuration reads on a request line. While the identity values are not yet valid, every such request gets a retry indication. Once the values are valid, requests are acknowledged and the registers hold steady. A free-running deadline counter starts at reset release. If the memory has not delivered all eight bytes after 2^TIMEOUT_W clocks, the block gives up, raises a timeout flag and publishes fixed default identifiers. It does the same, without the timeout flag, when the vendor field reads as blank (all ones). The default is TIMEOUT_W = 25, which is 2^25 clocks.

Top module: `idLoader`

## Requirements
- R1: While reset is low, idReady, timedOut and romReq are 0 and all four identifier outputs are 0.
- R2: With no other input, romReq is 1 and romAddr equals BASE_ADDR from the first rising edge after reset release onward.
- R3: Bytes are fetched one at a time at BASE_ADDR+0 up to BASE_ADDR+7 in ascending order. romAddr stays constant until romValid is sampled high while romReq is high, then it advances by one.
- R4: The fetched bytes map little-endian: vendorId = {byte1,byte0}, deviceId = {byte3,byte2}, subVendorId = {byte5,byte4}, subId = {byte7,byte6}, where byteN was read at BASE_ADDR+N.
- R5: idReady rises on the edge that accepts the eighth byte and then stays high until reset. romReq is 0 whenever idReady is 1.
- R6: While idReady is 0, a high cfgRdReq gives cfgRetry = 1 and cfgAck = 0 in the same cycle.
- R7: While idReady is 1, a high cfgRdReq gives cfgAck = 1 and cfgRetry = 0. With cfgRdReq low, both are 0.
- R8: If byte0 and byte1 are both 0xFF, the identifiers take the default parameter values, timedOut stays 0 and idReady still rises.
- R9: If the eighth byte has not been accepted by the 2^TIMEOUT_W-th rising edge after reset release, that edge sets idReady and timedOut, loads the default identifiers and drops romReq.
- R10: Asserting reset at any time aborts the fetch in progress. After release, the sequence restarts from BASE_ADDR+0 and reloads every identifier.
- R11: While idReady is 1, the four identifier outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (bus reset) |
| romAddr | output | ROM_AW | Byte address of the current memory read |
| romReq | output | 1 | Read request, held until the byte is delivered |
| romData | input | 8 | Byte returned by the memory |
| romValid | input | 1 | romData is valid this cycle |
| cfgRdReq | input | 1 | Configuration read request from the target logic |
| cfgRetry | output | 1 | Request must be retried, identifiers not valid |
| cfgAck | output | 1 | Request may complete with the identifier values |
| vendorId | output | 16 | Vendor identifier |
| deviceId | output | 16 | Device identifier |
| subVendorId | output | 16 | Subsystem vendor identifier |
| subId | output | 16 | Subsystem identifier |
| idReady | output | 1 | All four identifiers are valid |
| timedOut | output | 1 | Deadline expired and defaults were loaded |

## Verification
The bench builds the block with TIMEOUT_W = 6, so the deadline falls on the 64th edge after reset release instead of the 2^25th. This brings two timeout paths within a short run: a memory that never answers, and a memory slow enough that the deadline lands between the seventh and eighth byte. BASE_ADDR is set to a nonzero window (0x1F00), so a wrong offset or a wrong byte order in the fetch is visible on romAddr. Memory latencies of one and three cycles exercise the normal load at different paces.

// File: rtl/idLoaderPkg.sv
package idLoaderPkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 8;
  localparam int NUM_IDS   = NUM_BYTES / 2;
  localparam int ID_W      = 2 * BYTE_W;
  localparam int IDX_W     = $clog2(NUM_BYTES);

  // Strobes from the sequencing control to the identity datapath
  typedef struct packed {
    logic             capture;        // store romData at byteSel
    logic             commitRom;      // publish fetched identifiers
    logic             commitDefault;  // publish default identifiers
    logic [IDX_W-1:0] byteSel;        // byte slot being fetched
  } ldStrobes_t;
endpackage

// File: rtl/idLoaderCtl.sv
module idLoaderCtl
  import idLoaderPkg::*;
#(
  parameter int                ROM_AW    = 16,
  parameter logic [ROM_AW-1:0] BASE_ADDR = '0,
  parameter int                TIMEOUT_W = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              romValid,
  input  logic              vendorBlank,
  output logic              romReq,
  output logic [ROM_AW-1:0] romAddr,
  output ldStrobes_t        strobes,
  output logic              idReady,
  output logic              timedOut
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} ldState_e;

  ldState_e             state;
  logic [IDX_W-1:0]     byteIdx;
  logic [TIMEOUT_W-1:0] deadlineCnt;
  logic                 timedOutQ;
  logic                 lastByte;
  logic                 deadlineHit;

  assign lastByte    = (state == S_FETCH) && romValid && (byteIdx == LAST_IDX);
  assign deadlineHit = (deadlineCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      byteIdx     <= '0;
      deadlineCnt <= '0;
      timedOutQ   <= 1'b0;
    end else begin
      if (state != S_DONE) deadlineCnt <= deadlineCnt + 1'b1;
      unique case (state)
        S_IDLE:  state <= S_FETCH;
        S_FETCH: begin
          if (romValid) byteIdx <= byteIdx + 1'b1;
          if (lastByte) begin
            state <= S_DONE;
          end else if (deadlineHit) begin
            state     <= S_DONE;
            timedOutQ <= 1'b1;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    strobes               = '0;
    strobes.byteSel       = byteIdx;
    strobes.capture       = (state == S_FETCH) && romValid;
    strobes.commitRom     = lastByte && !vendorBlank;
    strobes.commitDefault = (lastByte && vendorBlank) ||
                            ((state == S_FETCH) && !lastByte && deadlineHit);
  end

  assign romReq   = (state == S_FETCH);
  assign romAddr  = BASE_ADDR + ROM_AW'(byteIdx);
  assign idReady  = (state == S_DONE);
  assign timedOut = timedOutQ;
endmodule

// File: rtl/idLoaderPath.sv
module idLoaderPath
  import idLoaderPkg::*;
#(
  parameter logic [15:0] DEF_VENDOR     = 16'h1D0F,
  parameter logic [15:0] DEF_DEVICE     = 16'h00A5,
  parameter logic [15:0] DEF_SUB_VENDOR = 16'h1D0F,
  parameter logic [15:0] DEF_SUB        = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobes_t        strobes,
  input  logic [BYTE_W-1:0] romData,
  output logic              vendorBlank,
  output logic [ID_W-1:0]   vendorId,
  output logic [ID_W-1:0]   deviceId,
  output logic [ID_W-1:0]   subVendorId,
  output logic [ID_W-1:0]   subId
);
  localparam int STAGE_N = NUM_BYTES - 1;

  logic [BYTE_W-1:0] stage   [STAGE_N];
  logic [BYTE_W-1:0] allBytes[NUM_BYTES];
  logic [ID_W-1:0]   fetched [NUM_IDS];
  logic [ID_W-1:0]   defaults[NUM_IDS];
  logic [ID_W-1:0]   idReg   [NUM_IDS];

  assign defaults[0] = DEF_VENDOR;
  assign defaults[1] = DEF_DEVICE;
  assign defaults[2] = DEF_SUB_VENDOR;
  assign defaults[3] = DEF_SUB;

  // The final byte is taken straight off the bus on the commit edge
  for (genvar b = 0; b < STAGE_N; b++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[b] <= '0;
      else if (strobes.capture && (strobes.byteSel == IDX_W'(b))) stage[b] <= romData;
    end
    assign allBytes[b] = stage[b];
  end
  assign allBytes[NUM_BYTES-1] = romData;

  for (genvar w = 0; w < NUM_IDS; w++) begin : g_word
    assign fetched[w] = {allBytes[2*w+1], allBytes[2*w]};
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     idReg[w] <= '0;
      else if (strobes.commitRom)     idReg[w] <= fetched[w];
      else if (strobes.commitDefault) idReg[w] <= defaults[w];
    end
  end

  assign vendorBlank = (stage[0] == '1) && (stage[1] == '1);
  assign vendorId    = idReg[0];
  assign deviceId    = idReg[1];
  assign subVendorId = idReg[2];
  assign subId       = idReg[3];
endmodule

// File: rtl/idLoader.sv
module idLoader
  import idLoaderPkg::*;
#(
  parameter int                ROM_AW         = 16,
  parameter logic [ROM_AW-1:0] BASE_ADDR      = '0,
  parameter int                TIMEOUT_W      = 25,
  parameter logic [15:0]       DEF_VENDOR     = 16'h1D0F,
  parameter logic [15:0]       DEF_DEVICE     = 16'h00A5,
  parameter logic [15:0]       DEF_SUB_VENDOR = 16'h1D0F,
  parameter logic [15:0]       DEF_SUB        = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romReq,
  input  logic [7:0]        romData,
  input  logic              romValid,
  input  logic              cfgRdReq,
  output logic              cfgRetry,
  output logic              cfgAck,
  output logic [15:0]       vendorId,
  output logic [15:0]       deviceId,
  output logic [15:0]       subVendorId,
  output logic [15:0]       subId,
  output logic              idReady,
  output logic              timedOut
);
  ldStrobes_t strobes;
  logic       vendorBlank;

  idLoaderCtl #(
    .ROM_AW(ROM_AW), .BASE_ADDR(BASE_ADDR), .TIMEOUT_W(TIMEOUT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .romValid(romValid), .vendorBlank(vendorBlank),
    .romReq(romReq), .romAddr(romAddr), .strobes(strobes),
    .idReady(idReady), .timedOut(timedOut)
  );

  idLoaderPath #(
    .DEF_VENDOR(DEF_VENDOR), .DEF_DEVICE(DEF_DEVICE),
    .DEF_SUB_VENDOR(DEF_SUB_VENDOR), .DEF_SUB(DEF_SUB)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .romData(romData),
    .vendorBlank(vendorBlank), .vendorId(vendorId), .deviceId(deviceId),
    .subVendorId(subVendorId), .subId(subId)
  );

  assign cfgRetry = cfgRdReq && !idReady;
  assign cfgAck   = cfgRdReq && idReady;
endmodule

// File: rtl/idLoaderChk.sv
module idLoaderChk #(
  parameter int ROM_AW    = 16,
  parameter int TIMEOUT_W = 25
) (
  input logic              clk,
  input logic              rstN,
  input logic [ROM_AW-1:0] romAddr,
  input logic              romReq,
  input logic              romValid,
  input logic              cfgRdReq,
  input logic              cfgRetry,
  input logic              cfgAck,
  input logic [15:0]       vendorId,
  input logic [15:0]       deviceId,
  input logic [15:0]       subVendorId,
  input logic [15:0]       subId,
  input logic              idReady,
  input logic              timedOut
);
  localparam logic [TIMEOUT_W:0] LIMIT = (TIMEOUT_W+1)'(1) << TIMEOUT_W;

  logic [TIMEOUT_W:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != LIMIT) sinceRst <= sinceRst + 1'b1;
  end

  // R6
  retry_while_loading_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdReq && !idReady) |-> (cfgRetry && !cfgAck));
  // R7
  no_retry_when_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReady |-> (!cfgRetry && (cfgAck == cfgRdReq)));
  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReady |=> idReady);
  // R5
  no_fetch_when_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReady |-> !romReq);
  // R11
  ids_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReady |=> ($stable(vendorId) && $stable(deviceId) &&
                 $stable(subVendorId) && $stable(subId)));
  // R9
  timeout_means_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> idReady);
  // R9
  deadline_met_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= LIMIT) |-> idReady);
  // R3
  addr_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && !romValid) |=> (!romReq || $stable(romAddr)));
endmodule

bind idLoader idLoaderChk #(.ROM_AW(ROM_AW), .TIMEOUT_W(TIMEOUT_W)) u_chk (.*);

// File: tb/idLoader_bench.sv
module idLoader_bench;
  localparam int          ROM_AW    = 16;
  localparam logic [15:0] BASE      = 16'h1F00;
  localparam int          TW        = 6;
  localparam int          LIMIT     = 1 << TW;
  localparam logic [15:0] D_VEN = 16'h1D0F, D_DEV = 16'h00A5, D_SVEN = 16'h1D0F, D_SUB = 16'h0001;

  logic        clk = 0;
  logic        rstN = 1;
  logic [15:0] romAddr;
  logic        romReq;
  logic [7:0]  romData = 0;
  logic        romValid = 0;
  logic        cfgRdReq = 0;
  logic        cfgRetry, cfgAck, idReady, timedOut;
  logic [15:0] vendorId, deviceId, subVendorId, subId;

  always #4 clk = ~clk;

  idLoader #(.ROM_AW(ROM_AW), .BASE_ADDR(BASE), .TIMEOUT_W(TW),
    .DEF_VENDOR(D_VEN), .DEF_DEVICE(D_DEV), .DEF_SUB_VENDOR(D_SVEN), .DEF_SUB(D_SUB)
  ) u_idLoader (.*);

  int checks = 0, fails = 0;
  bit checking = 0;

  // memory model state
  logic [7:0] mem[8];
  int  latency = 1;
  bit  silent = 0;
  bit  busy = 0;
  int  waitLeft = 0;
  int  heldAddr = 0;

  // reference model state
  int          mPhase = 0;   // 0 idle, 1 fetching, 2 done
  int          mIdx = 0, mEdges = 0;
  bit          mReady = 0, mTimed = 0;
  logic [7:0]  mBytes[$];
  logic [15:0] mVen = 0, mDev = 0, mSVen = 0, mSub = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic loadDefaults();
    mVen = D_VEN; mDev = D_DEV; mSVen = D_SVEN; mSub = D_SUB;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mIdx = 0; mEdges = 0; mReady = 0; mTimed = 0;
      mBytes.delete();
      mVen = 0; mDev = 0; mSVen = 0; mSub = 0;
    end else if (!mReady) begin
      mEdges++;
      if (mPhase == 0) mPhase = 1;
      else begin
        if (romValid) begin
          mBytes.push_back(romData);
          mIdx++;
        end
        if (mBytes.size() == 8) begin
          mReady = 1; mPhase = 2;
          if (mBytes[0] == 8'hFF && mBytes[1] == 8'hFF) loadDefaults();
          else begin
            mVen = {mBytes[1], mBytes[0]}; mDev = {mBytes[3], mBytes[2]};
            mSVen = {mBytes[5], mBytes[4]}; mSub = {mBytes[7], mBytes[6]};
          end
        end else if (mEdges == LIMIT) begin
          mReady = 1; mTimed = 1; mPhase = 2; loadDefaults();
        end
      end
    end
  end

  // compare every cycle, then drive the memory
  always @(negedge clk) begin
    if (checking) begin
      check(idReady == mReady, "R5 idReady", idReady, mReady);
      check(timedOut == mTimed, "R9 timedOut", timedOut, mTimed);
      check(romReq == (mPhase == 1), "R3 romReq", romReq, mPhase == 1);
      if (mPhase == 1) check(romAddr == BASE + mIdx, "R3 romAddr", romAddr, BASE + mIdx);
      check({vendorId, deviceId, subVendorId, subId} == {mVen, mDev, mSVen, mSub},
            mReady ? "R4,R11 ids" : "R4 ids",
            {vendorId, deviceId, subVendorId, subId}, {mVen, mDev, mSVen, mSub});
      check(cfgRetry == (cfgRdReq && !mReady), mReady ? "R7 retry" : "R6 retry",
            cfgRetry, cfgRdReq && !mReady);
      check(cfgAck == (cfgRdReq && mReady), mReady ? "R7 ack" : "R6 ack",
            cfgAck, cfgRdReq && mReady);
    end
    romValid <= 0;
    if (!rstN) busy = 0;
    else if (!silent) begin
      if (!busy && romReq) begin
        busy = 1; waitLeft = latency; heldAddr = romAddr - BASE;
      end else if (busy) begin
        waitLeft--;
        if (waitLeft == 0) begin
          romValid <= 1; romData <= mem[heldAddr[2:0]]; busy = 0;
        end
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic doReset();
    @(posedge clk); #2 rstN = 0; checking = 1;
    #1;
    check(!idReady && !timedOut && !romReq, "R1 ctrl in reset", {idReady, timedOut, romReq}, 0);
    check({vendorId, deviceId, subVendorId, subId} == 0, "R1 ids in reset",
          {vendorId, deviceId, subVendorId, subId}, 0);
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(posedge clk); @(negedge clk);
    check(romReq && romAddr == BASE, "R2 self start", {romReq, romAddr}, {1'b1, BASE});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2 cfgRdReq = (i % 3 != 0);
    end
  endtask

  task automatic setMem(input logic [63:0] v);
    for (int i = 0; i < 8; i++) mem[i] = v[8*i +: 8];
  endtask

  initial begin
    // normal load, latency 1
    setMem(64'h0042_10EE_7001_8086); latency = 1; silent = 0;
    doReset(); run(40);
    check(vendorId == 16'h8086 && subId == 16'h0042, "R4 mapping", {vendorId, subId}, 32'h8086_0042);
    // slower memory, latency 3
    setMem(64'hBEEF_CAFE_1234_5678); latency = 3;
    doReset(); run(50);
    check(deviceId == 16'h1234 && subVendorId == 16'hCAFE, "R4 mapping slow", {deviceId, subVendorId}, 32'h1234_CAFE);
    // blank vendor field
    setMem(64'h1111_2222_3333_FFFF); latency = 1;
    doReset(); run(40);
    check(vendorId == D_VEN && idReady && !timedOut, "R8 blank uses defaults", vendorId, D_VEN);
    // memory never answers
    silent = 1;
    doReset(); run(LIMIT + 10);
    check(timedOut && idReady && subId == D_SUB, "R9 silent timeout", {timedOut, idReady, subId}, {2'b11, D_SUB});
    // memory too slow: deadline between byte 7 and byte 8
    silent = 0; latency = 7; setMem(64'h0102_0304_0506_0708);
    doReset(); run(LIMIT + 10);
    check(timedOut && deviceId == D_DEV, "R9 slow timeout", {timedOut, deviceId}, {1'b1, D_DEV});
    // reset mid-load, then reload with fresh contents
    latency = 1; setMem(64'hAAAA_BBBB_CCCC_DDDD);
    doReset(); run(8);
    setMem(64'h0F0E_0D0C_0B0A_0908);
    doReset(); run(40);
    check(vendorId == 16'h0908 && subId == 16'h0F0E, "R10 restart reload", {vendorId, subId}, 32'h0908_0F0E);
    run(5);
    finishRun();
  end
endmodule